// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block holds the software-visible registers of one descriptor-driven DMA channel: a status word, a command pointer and three condition-select words (interrupt, branch, wait). Software never writes the status word directly. It writes a control word whose upper half is a bit mask and whose lower half carries the new values. Only the masked, writable bits change. The write then applies the run, pause, wake and flush rules: the channel is activated or deactivated, the sequencer is kicked, and the device is asked to flush.

The command sequencer sits beside this block. It reads the status and pointer outputs, and it reports its own effects back through dedicated inputs: killing the channel, halting it, clearing flush or wake, recording a taken branch, and advancing the command pointer. These inputs win over a bus write in the same cycle. A bus write to the command pointer is refused while the channel is active. An accepted pointer write is aligned to 16 bytes and starts a descriptor fetch.

Top module: `dmach_regfile`

## Requirements
- R1: Synchronous reset clears status, command pointer, all three select words, read data and the kick, flush and fetch pulses to zero.
- R2: A write to byte address 0x00 is a control write: bits [31:16] are a mask and bits [15:0] are values. Only status bits that are both masked and writable change. The writable bits are RUN (15), PAUSE (14), FLUSH (13), WAKE (12) and device status (7:0). DEAD (11), ACTIVE (10) and BRANCH-TAKEN (8) cannot be set this way. A bus write to the status address 0x04 has no effect.
- R3: After the mask is applied, WAKE=1 sets ACTIVE, and RUN=1 sets ACTIVE and clears DEAD. PAUSE=1 clears ACTIVE and overrides both.
- R4: A control write that changes RUN from 1 to 0 clears ACTIVE and DEAD. If FLUSH is set at that point, FLUSH is cleared.
- R5: kick_o pulses for one cycle, in the cycle after a control write whose result has ACTIVE=1. flush_o pulses for one cycle after a control write in which FLUSH was set when RUN fell, or in which FLUSH stays set.
- R6: A write to the command pointer (0x08) is ignored while ACTIVE=1. An accepted write stores the data with bits [3:0] cleared, and fetch_o pulses in the following cycle.
- R7: A bus write whose byte enables are not all ones (4'hF) is ignored.
- R8: When bus_re is high, bus_rdata takes, at the next edge, the value the addressed register held before that edge. Otherwise bus_rdata holds. The control address reads zero, and any address above 0x14 reads zero.
- R9: The interrupt (0x0C), branch (0x10) and wait (0x14) select words store and read back all 32 bits. They are presented on their own outputs.
- R10: The sequencer inputs act on status: kill sets DEAD and clears ACTIVE; halt clears ACTIVE, DEAD and FLUSH; flush-clear and wake-clear clear their bits; a branch-taken write loads bit 8. They take priority over a control write in the same cycle, and halt takes priority over kill.
- R11: A sequencer pointer load stores its value with bits [3:0] cleared whatever ACTIVE is. It wins over a bus pointer write in the same cycle, which then causes no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; writes need all four |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| seq_kill | input | 1 | Sequencer marks the channel dead |
| seq_halt | input | 1 | Sequencer stop command completed |
| seq_flush_clr | input | 1 | Sequencer clears FLUSH |
| seq_wake_clr | input | 1 | Sequencer clears WAKE at command fetch |
| seq_bt_we | input | 1 | Load branch-taken bit |
| seq_bt_val | input | 1 | Branch-taken value |
| seq_ptr_we | input | 1 | Sequencer command pointer load |
| seq_ptr | input | 32 | Sequencer command pointer value |
| status_o | output | 32 | Current status word |
| cmd_ptr_o | output | 32 | Current command pointer |
| intr_sel_o | output | 32 | Interrupt condition select |
| branch_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |
| kick_o | output | 1 | Pulse: start the sequencer |
| flush_o | output | 1 | Pulse: flush request to the device |
| fetch_o | output | 1 | Pulse: fetch the descriptor at cmd_ptr_o |

## Verification
The bench targets the ordering rules inside a single control write. Pause must beat run and wake, or the channel keeps running while paused. Setting FLUSH and clearing RUN in the same write must end with FLUSH cleared and exactly one flush pulse. It also tries to set DEAD and ACTIVE through the mask, which a design with the wrong writable mask would let through. It writes the pointer while active, which must not move it or start a fetch, and it collides sequencer updates with bus writes in one cycle, where the bus must lose. Partial-width writes are applied and must leave every register unchanged.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    // status bit positions (the sequencer decodes these)
    localparam int ST_RUN    = 15;
    localparam int ST_PAUSE  = 14;
    localparam int ST_FLUSH  = 13;
    localparam int ST_WAKE   = 12;
    localparam int ST_DEAD   = 11;
    localparam int ST_ACTIVE = 10;
    localparam int ST_BT     = 8;

    // bits a control write may touch
    localparam logic [HALF_W-1:0] CTL_WR_MASK = 16'hF0FF;

    typedef struct packed {
        logic [15:0] zero_hi;
        logic        run;
        logic        pause;
        logic        flush;
        logic        wake;
        logic        dead;
        logic        active;
        logic        rsvd9;
        logic        bt;
        logic [7:0]  devstat;
    } dmach_status_t;

    typedef enum logic [2:0] {
        RI_CTL  = 3'd0,
        RI_STAT = 3'd1,
        RI_PTR  = 3'd2,
        RI_ISEL = 3'd3,
        RI_BSEL = 3'd4,
        RI_WSEL = 3'd5,
        RI_NONE = 3'd7
    } dmach_reg_e;

    function automatic dmach_reg_e reg_of(input int unsigned widx);
        case (widx)
            0:       return RI_CTL;
            1:       return RI_STAT;
            2:       return RI_PTR;
            3:       return RI_ISEL;
            4:       return RI_BSEL;
            5:       return RI_WSEL;
            default: return RI_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dmach_ctl_eval.sv
module dmach_ctl_eval
    import dmach_pkg::*;
(
    input  dmach_status_t      cur,
    input  logic [WORD_W-1:0]  wdata,
    output dmach_status_t      nxt,
    output logic               kick,
    output logic               flush
);
    logic [HALF_W-1:0] msk;
    logic [WORD_W-1:0] merged;
    dmach_status_t     s;

    always_comb begin
        msk    = wdata[WORD_W-1:HALF_W] & CTL_WR_MASK;
        merged = (WORD_W'(cur) & ~{{HALF_W{1'b0}}, msk})
               | {{HALF_W{1'b0}}, wdata[HALF_W-1:0] & msk};
        s      = dmach_status_t'(merged);
        flush  = 1'b0;
        if (s.wake) s.active = 1'b1;
        if (s.run) begin
            s.active = 1'b1;
            s.dead   = 1'b0;
        end
        if (s.pause) s.active = 1'b0;
        if (cur.run && !s.run) begin
            s.active = 1'b0;
            s.dead   = 1'b0;
            if (s.flush) begin
                flush   = 1'b1;
                s.flush = 1'b0;
            end
        end
        if (s.flush) flush = 1'b1;
        kick = s.active;
        nxt  = s;
    end
endmodule

// File: rtl/dmach_cmdptr.sv
module dmach_cmdptr
    import dmach_pkg::*;
#(
    parameter int ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_data,
    input  logic              locked,
    input  logic              seq_we,
    input  logic [WORD_W-1:0] seq_data,
    output logic [WORD_W-1:0] ptr_o,
    output logic              fetch_o
);
    localparam logic [WORD_W-1:0] ALIGN_MASK =
        {{(WORD_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o   <= '0;
            fetch_o <= 1'b0;
        end else begin
            fetch_o <= 1'b0;
            if (seq_we) begin
                ptr_o <= seq_data & ALIGN_MASK;
            end else if (bus_we && !locked) begin
                ptr_o   <= bus_data & ALIGN_MASK;
                fetch_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmach_selbank.sv
module dmach_selbank
    import dmach_pkg::*;
#(
    parameter int NSEL = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NSEL-1:0]              we,
    input  logic [WORD_W-1:0]            wdata,
    output logic [NSEL-1:0][WORD_W-1:0]  q
);
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= '0;
            else if (we[i]) q[i] <= wdata;
        end
    end
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
    import dmach_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PTR_ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              seq_kill,
    input  logic              seq_halt,
    input  logic              seq_flush_clr,
    input  logic              seq_wake_clr,
    input  logic              seq_bt_we,
    input  logic              seq_bt_val,
    input  logic              seq_ptr_we,
    input  logic [31:0]       seq_ptr,
    output logic [31:0]       status_o,
    output logic [31:0]       cmd_ptr_o,
    output logic [31:0]       intr_sel_o,
    output logic [31:0]       branch_sel_o,
    output logic [31:0]       wait_sel_o,
    output logic              kick_o,
    output logic              flush_o,
    output logic              fetch_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int NSEL  = 3;

    logic [IDX_W-1:0] widx;
    dmach_reg_e       rsel;
    logic             wr_ok, ctl_we;

    dmach_status_t st_q, st_n, ev_st;
    logic          ev_kick, ev_flush;

    logic [NSEL-1:0]             sel_we;
    logic [NSEL-1:0][WORD_W-1:0] sel_q;
    logic [WORD_W-1:0]           rd_mux;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign rsel   = reg_of(32'(widx));
    assign wr_ok  = bus_we && (bus_be == 4'hF);
    assign ctl_we = wr_ok && (rsel == RI_CTL);

    dmach_ctl_eval u_eval (
        .cur   (st_q),
        .wdata (bus_wdata),
        .nxt   (ev_st),
        .kick  (ev_kick),
        .flush (ev_flush)
    );

    // sequencer reports override a same-cycle control write
    always_comb begin
        st_n = ctl_we ? ev_st : st_q;
        if (seq_kill) begin
            st_n.dead   = 1'b1;
            st_n.active = 1'b0;
        end
        if (seq_halt) begin
            st_n.active = 1'b0;
            st_n.dead   = 1'b0;
            st_n.flush  = 1'b0;
        end
        if (seq_flush_clr) st_n.flush = 1'b0;
        if (seq_wake_clr)  st_n.wake  = 1'b0;
        if (seq_bt_we)     st_n.bt    = seq_bt_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            kick_o  <= 1'b0;
            flush_o <= 1'b0;
        end else begin
            st_q    <= st_n;
            kick_o  <= ctl_we && ev_kick;
            flush_o <= ctl_we && ev_flush;
        end
    end

    dmach_cmdptr #(.ALIGN_BITS(PTR_ALIGN)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (wr_ok && (rsel == RI_PTR)),
        .bus_data (bus_wdata),
        .locked   (st_q.active),
        .seq_we   (seq_ptr_we),
        .seq_data (seq_ptr),
        .ptr_o    (cmd_ptr_o),
        .fetch_o  (fetch_o)
    );

    assign sel_we[0] = wr_ok && (rsel == RI_ISEL);
    assign sel_we[1] = wr_ok && (rsel == RI_BSEL);
    assign sel_we[2] = wr_ok && (rsel == RI_WSEL);

    dmach_selbank #(.NSEL(NSEL)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .we    (sel_we),
        .wdata (bus_wdata),
        .q     (sel_q)
    );

    always_comb begin
        case (rsel)
            RI_STAT: rd_mux = WORD_W'(st_q);
            RI_PTR:  rd_mux = cmd_ptr_o;
            RI_ISEL: rd_mux = sel_q[0];
            RI_BSEL: rd_mux = sel_q[1];
            RI_WSEL: rd_mux = sel_q[2];
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    assign status_o     = WORD_W'(st_q);
    assign intr_sel_o   = sel_q[0];
    assign branch_sel_o = sel_q[1];
    assign wait_sel_o   = sel_q[2];
endmodule

// File: rtl/dmach_regfile_chk.sv
module dmach_regfile_chk
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              seq_kill,
    input logic              seq_halt,
    input logic              seq_ptr_we,
    input logic [31:0]       status_o,
    input logic [31:0]       cmd_ptr_o,
    input logic              kick_o,
    input logic              fetch_o
);
    logic full_wr, ctl_wr, ptr_wr;
    assign full_wr = bus_we && (bus_be == 4'hF);
    assign ctl_wr  = full_wr && (bus_addr[ADDR_W-1:2] == '0);
    assign ptr_wr  = full_wr && (32'(bus_addr[ADDR_W-1:2]) == 2);

    // R6
    ptr_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[ST_ACTIVE] && !seq_ptr_we) |=> $stable(cmd_ptr_o));

    // R6
    fetch_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> $past(ptr_wr && !status_o[ST_ACTIVE] && !seq_ptr_we));

    // R5
    kick_cause_chk: assert property (@(posedge clk) disable iff (rst)
        kick_o |-> $past(ctl_wr));

    // R3
    pause_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && bus_wdata[HALF_W + ST_PAUSE] && bus_wdata[ST_PAUSE])
        |=> !status_o[ST_ACTIVE]);

    // R4
    run_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_o[ST_RUN]) && !$past(seq_kill))
        |-> (!status_o[ST_ACTIVE] && !status_o[ST_DEAD]));

    // R10
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        seq_halt |=> (!status_o[ST_ACTIVE] && !status_o[ST_DEAD]));
endmodule

bind dmach_regfile dmach_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .seq_kill   (seq_kill),
    .seq_halt   (seq_halt),
    .seq_ptr_we (seq_ptr_we),
    .status_o   (status_o),
    .cmd_ptr_o  (cmd_ptr_o),
    .kick_o     (kick_o),
    .fetch_o    (fetch_o)
);

// File: tb/dmach_regfile_tb.sv
module dmach_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        seq_kill = 1'b0, seq_halt = 1'b0, seq_flush_clr = 1'b0;
    logic        seq_wake_clr = 1'b0, seq_bt_we = 1'b0, seq_bt_val = 1'b0;
    logic        seq_ptr_we = 1'b0;
    logic [31:0] seq_ptr = '0;
    logic [31:0] status_o, cmd_ptr_o, intr_sel_o, branch_sel_o, wait_sel_o;
    logic        kick_o, flush_o, fetch_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmach_regfile u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .seq_kill(seq_kill), .seq_halt(seq_halt),
        .seq_flush_clr(seq_flush_clr), .seq_wake_clr(seq_wake_clr),
        .seq_bt_we(seq_bt_we), .seq_bt_val(seq_bt_val),
        .seq_ptr_we(seq_ptr_we), .seq_ptr(seq_ptr), .status_o(status_o),
        .cmd_ptr_o(cmd_ptr_o), .intr_sel_o(intr_sel_o),
        .branch_sel_o(branch_sel_o), .wait_sel_o(wait_sel_o),
        .kick_o(kick_o), .flush_o(flush_o), .fetch_o(fetch_o)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_st, m_ptr, m_rd;
    logic [31:0] m_sel [3];
    logic        m_kick, m_flush, m_fetch;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a >> 2)
            1:       return m_st;
            2:       return m_ptr;
            3:       return m_sel[0];
            4:       return m_sel[1];
            5:       return m_sel[2];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] s, old;
        logic [15:0] mk;
        bit          wr;
        int          w;
        if (rst) begin
            m_st = 0; m_ptr = 0; m_rd = 0;
            m_sel[0] = 0; m_sel[1] = 0; m_sel[2] = 0;
            m_kick = 0; m_flush = 0; m_fetch = 0;
        end else begin
            m_kick = 0; m_flush = 0; m_fetch = 0;
            if (bus_re) m_rd = m_read(bus_addr);
            wr  = bus_we && (bus_be == 4'hF);
            w   = int'(bus_addr >> 2);
            old = m_st;
            s   = m_st;
            if (wr && w == 0) begin
                mk = bus_wdata[31:16] & 16'hF0FF;
                s  = (s & ~{16'h0, mk}) | {16'h0, bus_wdata[15:0] & mk};
                if (s[12]) s[10] = 1'b1;
                if (s[15]) begin s[10] = 1'b1; s[11] = 1'b0; end
                if (s[14]) s[10] = 1'b0;
                if (old[15] && !s[15]) begin
                    s[10] = 1'b0; s[11] = 1'b0;
                    if (s[13]) begin m_flush = 1; s[13] = 1'b0; end
                end
                if (s[13]) m_flush = 1;
                m_kick = s[10];
            end
            if (seq_kill) begin s[11] = 1'b1; s[10] = 1'b0; end
            if (seq_halt) begin s[10] = 1'b0; s[11] = 1'b0; s[13] = 1'b0; end
            if (seq_flush_clr) s[13] = 1'b0;
            if (seq_wake_clr)  s[12] = 1'b0;
            if (seq_bt_we)     s[8]  = seq_bt_val;
            if (seq_ptr_we) m_ptr = seq_ptr & ~32'hF;
            else if (wr && w == 2 && !old[10]) begin
                m_ptr = bus_wdata & ~32'hF;
                m_fetch = 1;
            end
            if (wr && w >= 3 && w <= 5) m_sel[w-3] = bus_wdata;
            m_st = s;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R2 status", status_o, m_st);
            chk("R6 cmd_ptr", cmd_ptr_o, m_ptr);
            chk("R9 intr_sel", intr_sel_o, m_sel[0]);
            chk("R9 branch_sel", branch_sel_o, m_sel[1]);
            chk("R9 wait_sel", wait_sel_o, m_sel[2]);
            chk("R8 rdata", bus_rdata, m_rd);
            chk("R5 kick", 32'(kick_o), 32'(m_kick));
            chk("R5 flush", 32'(flush_o), 32'(m_flush));
            chk("R6 fetch", 32'(fetch_o), 32'(m_fetch));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clr();
        bus_we = 0; bus_re = 0; bus_be = 4'hF; bus_addr = 0; bus_wdata = 0;
        seq_kill = 0; seq_halt = 0; seq_flush_clr = 0; seq_wake_clr = 0;
        seq_bt_we = 0; seq_bt_val = 0; seq_ptr_we = 0; seq_ptr = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk); clr();
        bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk); clr();
        bus_re = 1; bus_addr = a;
    endtask

    task automatic settle();
        @(negedge clk); clr();
    endtask

    initial begin
        clr();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_en = 1;
        // R1: reset state
        chk("R1 status", status_o, 32'h0);
        chk("R1 ptr", cmd_ptr_o, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);

        // R6: accepted pointer write, aligned, fetch
        wr(8'h08, 32'h0000_1237, 4'hF); settle();
        chk("R6 ptr aligned", cmd_ptr_o, 32'h0000_1230);
        chk("R6 fetch", 32'(fetch_o), 32'd1);
        rd(8'h08); settle();
        chk("R8 read ptr", bus_rdata, 32'h0000_1230);

        // R2: device status via mask
        wr(8'h00, 32'h00FF_00A5, 4'hF); settle();
        chk("R2 devstat", status_o, 32'h0000_00A5);
        chk("R5 no kick when inactive", 32'(kick_o), 32'd0);
        // R2: DEAD/ACTIVE not writable, status address write ignored
        wr(8'h00, 32'h0C00_0C00, 4'hF); settle();
        chk("R2 dead/active locked", status_o, 32'h0000_00A5);
        wr(8'h04, 32'hFFFF_FFFF, 4'hF); settle();
        chk("R2 status addr ignored", status_o, 32'h0000_00A5);
        // R7: partial write ignored
        wr(8'h00, 32'h8000_8000, 4'h3); settle();
        chk("R7 partial ctl", status_o, 32'h0000_00A5);
        wr(8'h0C, 32'h1111_1111, 4'h1); settle();
        chk("R7 partial sel", intr_sel_o, 32'h0);

        // R3: run
        wr(8'h00, 32'h8000_8000, 4'hF); settle();
        chk("R3 run", status_o, 32'h0000_84A5);
        chk("R5 kick on run", 32'(kick_o), 32'd1);
        // R6: locked pointer
        wr(8'h08, 32'h0000_2000, 4'hF); settle();
        chk("R6 ptr locked", cmd_ptr_o, 32'h0000_1230);
        chk("R6 no fetch", 32'(fetch_o), 32'd0);
        // R3: pause overrides
        wr(8'h00, 32'h4000_4000, 4'hF); settle();
        chk("R3 pause", status_o, 32'h0000_C0A5);
        wr(8'h00, 32'h4000_0000, 4'hF); settle();
        chk("R3 unpause", status_o, 32'h0000_84A5);
        // R10: kill
        @(negedge clk); clr(); seq_kill = 1; settle();
        chk("R10 kill", status_o, 32'h0000_88A5);
        // R5: flush stays set
        wr(8'h00, 32'h2000_2000, 4'hF); settle();
        chk("R3 run clears dead", status_o, 32'h0000_A4A5);
        chk("R5 flush pulse", 32'(flush_o), 32'd1);
        // R4: run fall with flush
        wr(8'h00, 32'h8000_0000, 4'hF); settle();
        chk("R4 run fall", status_o, 32'h0000_00A5);
        chk("R4 flush pulse", 32'(flush_o), 32'd1);
        chk("R4 no kick", 32'(kick_o), 32'd0);
        // R3: wake
        wr(8'h00, 32'h1000_1000, 4'hF); settle();
        chk("R3 wake", status_o, 32'h0000_14A5);
        // R10: halt beats control write
        wr(8'h00, 32'h8000_8000, 4'hF); seq_halt = 1; settle();
        chk("R10 halt priority", status_o, 32'h0000_90A5);
        // R11: sequencer pointer beats bus pointer write
        wr(8'h08, 32'h0000_5550, 4'hF); seq_ptr_we = 1; seq_ptr = 32'h0000_4447; settle();
        chk("R11 seq ptr wins", cmd_ptr_o, 32'h0000_4440);
        chk("R11 no fetch", 32'(fetch_o), 32'd0);
        wr(8'h00, 32'h1000_1000, 4'hF); settle();
        chk("R11 active again", status_o, 32'h0000_94A5);
        @(negedge clk); clr(); seq_ptr_we = 1; seq_ptr = 32'h0000_888F; settle();
        chk("R11 seq ptr while active", cmd_ptr_o, 32'h0000_8880);
        // R10: wake clear and branch-taken
        @(negedge clk); clr(); seq_wake_clr = 1; seq_bt_we = 1; seq_bt_val = 1; settle();
        chk("R10 wake clr bt", status_o, 32'h0000_85A5);
        @(negedge clk); clr(); seq_kill = 1; seq_halt = 1; settle();
        chk("R10 halt over kill", status_o, 32'h0000_81A5);
        // R9/R8: select words
        wr(8'h0C, 32'h000F_0003, 4'hF);
        wr(8'h10, 32'hDEAD_BEEF, 4'hF);
        wr(8'h14, 32'h1234_5678, 4'hF); settle();
        chk("R9 intr", intr_sel_o, 32'h000F_0003);
        chk("R9 branch", branch_sel_o, 32'hDEAD_BEEF);
        chk("R9 wait", wait_sel_o, 32'h1234_5678);
        rd(8'h10); settle();
        chk("R8 read branch sel", bus_rdata, 32'hDEAD_BEEF);
        rd(8'h00); settle();
        chk("R8 ctl reads zero", bus_rdata, 32'h0);
        rd(8'h04); settle();
        chk("R8 read status", bus_rdata, 32'h0000_81A5);
        rd(8'h3C); settle();
        chk("R8 unused reads zero", bus_rdata, 32'h0);

        // mixed traffic checked against the model every clock
        for (int i = 0; i < 600; i++) begin
            int op;
            @(negedge clk); clr();
            op = int'($urandom % 8);
            case (op)
                0, 1, 2: begin bus_we = 1; bus_addr = 8'h00; bus_wdata = $urandom; end
                3:       begin bus_we = 1; bus_addr = 8'h08; bus_wdata = $urandom; end
                4:       begin bus_we = 1; bus_addr = 8'(4 * (3 + $urandom % 3)); bus_wdata = $urandom; end
                5:       begin bus_re = 1; bus_addr = 8'(4 * ($urandom % 8)); end
                6:       begin bus_we = 1; bus_addr = 8'h04; bus_wdata = $urandom; end
                default: ;
            endcase
            if ($urandom % 8 == 0) bus_be = 4'($urandom);
            seq_kill      = ($urandom % 10 == 0);
            seq_halt      = ($urandom % 12 == 0);
            seq_flush_clr = ($urandom % 10 == 0);
            seq_wake_clr  = ($urandom % 6 == 0);
            seq_bt_we     = ($urandom % 8 == 0);
            seq_bt_val    = 1'($urandom);
            seq_ptr_we    = ($urandom % 10 == 0);
            seq_ptr       = $urandom;
        end
        settle();
        settle();
        cmp_en = 0;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule